// File: doc/BRIEF.md
# Two-Wire Delta-Sigma Readout Controller

This block sits on the host side of a delta-sigma converter that shares one pin for both "sample ready" and serial data, and takes its shift clock from the host. When a request arrives, the controller waits for the shared line to drop low. It then generates the serial clock and shifts in a two's-complement word, most significant bit first. It presents the word on a parallel output with a one-cycle valid strobe.

Commands to the converter are expressed only by how many clocks follow the data and by the level at which the clock is left idle. One extra clock makes the converter drive its line high. Two extra clocks start a self-calibration. Leaving the clock parked high puts the converter into standby, so that the next request wakes it and yields one conversion. Parking after one extra clock makes the converter calibrate when it wakes.

The serial clock half-period is set in system clocks by a parameter. The shared line passes through a synchronizer before the controller uses it.

Top module: `adc_link_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `sclk_o` is low, `sample_vld_o` is low and `sample_o` is zero.
- R2: After a request, the serial clock stays low for at least HALF_CYC cycles and makes no rising edge while the synchronized line is high; a low line may be followed by a rising edge with no further delay.
- R3: WORD_W bits are shifted in MSB first, each taken at the end of a high phase; `sample_o` takes the word, with `sample_vld_o` high for exactly one cycle, in the cycle the WORD_W-th falling edge appears; `sample_o` holds its value otherwise.
- R4: During a transfer every high and low phase of `sclk_o` lasts exactly HALF_CYC cycles, so the first rising edge is followed by the last falling edge after (2N-1)·HALF_CYC cycles for N clocks; no phase at any time is shorter than HALF_CYC cycles.
- R5: Mode code 1 gives WORD_W+1 clocks (line forced high) and mode code 2 gives WORD_W+2 clocks (calibration); both leave the clock low.
- R6: Mode code 3 gives WORD_W clocks and mode code 4 gives WORD_W+1 clocks; after a final low phase of HALF_CYC cycles the clock rises and is then held high until the next request.
- R7: A request while the clock is parked high drives it low within one cycle (wake), before any wait for the ready level.
- R8: After a transfer of exactly WORD_W clocks (codes 0, 3 and 5–7), the line may still show the last data bit; a low level is then not taken as ready until the synchronized line has been seen high.
- R9: The mode is sampled only when the request is accepted; a request during a transfer is ignored and starts nothing later.
- R10: Mode codes 5, 6 and 7 behave as code 0 (WORD_W clocks, clock left low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request to run a transfer (taken only when idle) |
| mode_i | input | 3 | Transfer kind: 0 read, 1 read+force high, 2 read+calibrate, 3 single shot, 4 single shot+calibrate on wake |
| sample_o | output | WORD_W | Last received word, two's complement |
| sample_vld_o | output | 1 | One-cycle strobe when `sample_o` updates |
| sclk_o | output | 1 | Serial clock to the converter |
| line_i | input | 1 | Shared ready (active low) / serial data line from the converter |

## Verification
A stimulus table drives each mode code with data words chosen to separate bit order and sign: an alternating pattern, a lone sign bit, all ones below the sign, all ones and a single low bit. Each row reads back the word and counts rising and falling clock edges, which distinguishes the plain, force-high and calibration tails and the parked endings from one another. Each row also measures the span from the first rising to the last falling edge, which exposes a wrong half-period. Directed cases hold the line high after a request to show that no clock appears early, and leave a low last bit on the line to show that it is not mistaken for ready. They also issue a second request mid-transfer with a different code, which shows that the running mode is kept and that nothing is queued.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_WAIT,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } link_state_t;

    typedef struct packed {
        logic [1:0] extra;  // clocks after the data word
        logic       park;   // leave the clock high afterwards
    } mode_cfg_t;

    // 0 read, 1 read+force high, 2 read+calibrate,
    // 3 single shot, 4 single shot with calibration on wake, others: read
    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t c;
        c.extra = 2'd0;
        c.park  = 1'b0;
        case (code)
            3'd1: c.extra = 2'd1;
            3'd2: c.extra = 2'd2;
            3'd3: c.park  = 1'b1;
            3'd4: begin
                c.extra = 2'd1;
                c.park  = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_link_sync.sv
module adc_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb ff_d = d_i;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], d_i};
        end
    endgenerate

    // idle level of the shared line is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/adc_link_halftimer.sv
module adc_link_halftimer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)          cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/adc_link_shreg.sv
module adc_link_shreg #(
    parameter int WORD_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    // only WORD_W-1 bits are stored; the last bit joins on the way out
    logic [WORD_W-2:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (en_i) sh_d = {sh_q[WORD_W-3:0], bit_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign word_o = {sh_q, bit_i};
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int HALF_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [2:0]        mode_i,
    output logic [WORD_W-1:0] sample_o,
    output logic              sample_vld_o,
    output logic              sclk_o,
    input  logic              line_i
);
    localparam int CNT_W = $clog2(WORD_W + 3);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        link_state_t       st;
        logic              sclk;
        logic              stale;
        logic [1:0]        extra;
        logic              park;
        logic [CNT_W-1:0]  nbit;
        logic              vld;
        logic [WORD_W-1:0] sample;
    } ctl_t;

    ctl_t d, q;

    logic              line_s;
    logic              tick;
    logic              restart;
    logic              shift_en;
    logic [WORD_W-1:0] word_now;
    logic [CNT_W-1:0]  stop_at;
    mode_cfg_t         cfg;

    adc_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (line_i),
        .q_o    (line_s)
    );

    adc_link_halftimer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_o    (tick)
    );

    adc_link_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (shift_en),
        .bit_i  (line_s),
        .word_o (word_now)
    );

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        restart  = 1'b0;
        shift_en = 1'b0;
        cfg      = decode_mode(mode_i);
        stop_at  = WORD_CNT + CNT_W'(q.extra);

        case (q.st)
            ST_IDLE: begin
                if (line_s) d.stale = 1'b0;
                if (req_i) begin
                    d.extra = cfg.extra;
                    d.park  = cfg.park;
                    d.nbit  = '0;
                    d.sclk  = 1'b0;      // wakes a parked converter
                    restart = 1'b1;
                    d.st    = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (line_s) d.stale = 1'b0;
                if (tick) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (line_s) begin
                    d.stale = 1'b0;
                end else if (!q.stale) begin
                    d.sclk  = 1'b1;
                    restart = 1'b1;
                    d.st    = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.sclk  = 1'b0;
                    restart = 1'b1;
                    d.nbit  = q.nbit + 1'b1;
                    if (q.nbit < WORD_CNT) shift_en = 1'b1;
                    if (q.nbit == LAST_BIT) begin
                        d.vld    = 1'b1;
                        d.sample = word_now;
                    end
                    if (q.nbit + 1'b1 == stop_at) d.st = ST_TAIL;
                    else                          d.st = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.sclk  = 1'b1;
                    restart = 1'b1;
                    d.st    = ST_HIGH;
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.sclk  = q.park;
                    d.stale = (q.extra == 2'd0);
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st     <= ST_IDLE;
            q.sclk   <= 1'b0;
            q.stale  <= 1'b0;
            q.extra  <= '0;
            q.park   <= 1'b0;
            q.nbit   <= '0;
            q.vld    <= 1'b0;
            q.sample <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o       = q.sclk;
    assign sample_o     = q.sample;
    assign sample_vld_o = q.vld;
endmodule

// File: rtl/adc_link_ctrl_chk.sv
module adc_link_ctrl_chk
    import adc_link_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int HALF_CYC = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sclk_i,
    input logic              vld_i,
    input logic [WORD_W-1:0] sample_i,
    input link_state_t       st_i,
    input logic              stale_i,
    input logic              line_i
);
    localparam int RUN_W = $clog2(HALF_CYC + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic             prev_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= sclk_i;
            if (sclk_i != prev_q)    run_q <= RUN_W'(1);
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assert_vld_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |=> !vld_i);

    assert_vld_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |-> (!sclk_i && $past(sclk_i)));

    assert_sample_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |-> $stable(sample_i));

    assert_min_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_i != prev_q) |-> (run_q >= RUN_W'(HALF_CYC)));

    assert_rise_needs_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sclk_i) && $past(st_i) == ST_WAIT) |-> !$past(line_i));

    assert_stale_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_i) == ST_WAIT && $past(stale_i)) |-> !$rose(sclk_i));

    assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_i) == ST_IDLE && st_i == ST_IDLE) |-> $stable(sclk_i));
endmodule

bind adc_link_ctrl adc_link_ctrl_chk #(
    .WORD_W   (WORD_W),
    .HALF_CYC (HALF_CYC)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (sclk_o),
    .vld_i    (sample_vld_o),
    .sample_i (sample_o),
    .st_i     (q.st),
    .stale_i  (q.stale),
    .line_i   (line_s)
);

// File: tb/adc_link_ctrl_test.sv
module adc_link_ctrl_test;
    localparam int HALF = 8;
    localparam int W    = 24;
    localparam int NV   = 7;

    localparam logic [2:0]   T_MODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd3, 3'd7, 3'd0};
    localparam logic [23:0]  T_WORD [NV] = '{24'h5A3C81, 24'h800000, 24'h7FFFFF,
                                             24'hFFFFFF, 24'h000001, 24'h123457, 24'hA5A5A5};
    localparam int           T_N    [NV] = '{24, 25, 26, 25, 24, 24, 24};
    localparam logic         T_PARK [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [23:0] sample;
    logic        vld;
    logic        sclk;
    logic        line;

    always #2 clk = ~clk;

    adc_link_ctrl #(.WORD_W(W), .HALF_CYC(HALF), .SYNC_STAGES(2)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_i        (req),
        .mode_i       (mode),
        .sample_o     (sample),
        .sample_vld_o (vld),
        .sclk_o       (sclk),
        .line_i       (line)
    );

    // converter model
    int          rises = 0;
    int          falls = 0;
    int          base  = 0;
    logic        armed = 1'b0;
    logic        idle_lvl = 1'b1;
    logic [23:0] word_m = '0;
    logic        model_bit;
    time         first_rise_t = 0;
    time         last_fall_t = 0;

    always_comb begin
        int k;
        k = rises - base;
        if (k <= 0)       model_bit = 1'b0;
        else if (k <= 24) model_bit = word_m[24-k];
        else              model_bit = 1'b1;
    end
    assign line = armed ? model_bit : idle_lvl;

    always @(posedge sclk) begin
        if (rises == base) first_rise_t = $time;
        rises = rises + 1;
    end
    always @(negedge sclk) begin
        falls = falls + 1;
        last_fall_t = $time;
    end

    // output monitors
    int          vld_cnt = 0;
    logic [23:0] got = '0;
    int          min_w = 1000000;
    int          run = 0;
    logic        prev_s = 1'b0;
    always @(negedge clk) begin
        if (vld === 1'b1) begin
            vld_cnt = vld_cnt + 1;
            got = sample;
        end
        if (sclk !== prev_s) begin
            if (run < min_w) min_w = run;
            run = 1;
            prev_s = sclk;
        end else begin
            run = run + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        if (m == 3'd1 || m == 3'd2) return "R5";
        if (m == 3'd3 || m == 3'd4) return "R6";
        if (m >= 3'd5)              return "R10";
        return "R3";
    endfunction

    task automatic issue_req(input logic [2:0] m);
        @(negedge clk);
        req  = 1'b1;
        mode = m;
        @(negedge clk);
        req  = 1'b0;
    endtask

    task automatic run_xfer(input logic [2:0] m, input logic [23:0] w, input int n,
                            input logic park, input bit mid_req, input logic leave_lvl);
        int f0;
        int v0;
        f0 = falls;
        v0 = vld_cnt;
        word_m = w;
        base   = rises;
        armed  = 1'b1;
        if (mid_req) begin
            repeat (10 * HALF) @(negedge clk);
            issue_req(3'd2);          // R9: ignored, mode kept
            repeat (42 * HALF + 38) @(negedge clk);
        end else begin
            repeat (52 * HALF + 40) @(negedge clk);
        end
        chk(mode_tag(m), rises - base, n + int'(park));
        chk(mode_tag(m), falls - f0, n);
        chk(park ? "R6" : "R5", sclk, park);
        chk("R3", vld_cnt - v0, 1);
        chk("R3", got, w);
        chk("R4", (last_fall_t - first_rise_t) / 4, (2 * n - 1) * HALF);
        idle_lvl = leave_lvl;
        armed    = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1", sclk, 0);
        chk("R1", vld, 0);
        chk("R1", sample, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", sclk, 0);

        // table of modes and words
        for (int i = 0; i < NV; i++) begin
            int r0;
            r0 = rises;
            issue_req(T_MODE[i]);
            repeat (2 * HALF + 10) @(negedge clk);
            chk("R2", rises - r0, 0);
            chk("R7", sclk, 0);
            run_xfer(T_MODE[i], T_WORD[i], T_N[i], T_PARK[i], 1'b0, 1'b1);
            repeat (5) @(negedge clk);
        end

        // R8: a low last bit left on the line is not taken as ready
        issue_req(3'd0);
        repeat (2 * HALF + 10) @(negedge clk);
        run_xfer(3'd0, 24'h000002, 24, 1'b0, 1'b0, 1'b0);
        begin
            int r0;
            r0 = rises;
            issue_req(3'd0);
            repeat (2 * HALF + 40) @(negedge clk);
            chk("R8", rises - r0, 0);
            idle_lvl = 1'b1;
            repeat (10) @(negedge clk);
            run_xfer(3'd0, 24'hC3C3C3, 24, 1'b0, 1'b0, 1'b1);
        end

        // R9: request during a transfer is ignored and not queued
        issue_req(3'd0);
        repeat (2 * HALF + 10) @(negedge clk);
        run_xfer(3'd0, 24'h0F0F0F, 24, 1'b0, 1'b1, 1'b1);
        begin
            int v0;
            v0 = vld_cnt;
            word_m = 24'h111111;
            base   = rises;
            armed  = 1'b1;
            repeat (200) @(negedge clk);
            chk("R9", rises - base, 0);
            chk("R9", vld_cnt - v0, 0);
            armed = 1'b0;
        end

        // R4: no phase anywhere shorter than the half period
        chk("R4", (min_w >= HALF) ? 1 : 0, 1);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule